// File: doc/BRIEF.md
# HDLC Receive Queue and Interrupt Controller

This block sits behind a bit-level HDLC deframer. For each received byte the deframer gives the byte and three condition flags: receive overrun, closing flag seen, and frame too short. The block keeps the bytes in a small first-in first-out queue. Each byte carries its own condition bits. Software sees the oldest byte and its status word on two read ports. A one-cycle read strobe retires that byte.

Two level interrupts leave the block. The normal receive interrupt follows a two-bit mode field. In one mode it fires once on the first stored character and must then be re-armed. In the other mode it stays high while the queue holds more characters than a 3-bit threshold.

The special-condition interrupt is raised by any flagged byte or by a byte that finds the queue full. It freezes intake until software issues an error-reset command. A flagged byte is not always queued. When it is not queued, it is parked in a separate holding register, which software reads ahead of the queue.

Top module: `hdlc_rxq_ctrl`

## Requirements
- R1: Bytes leave in arrival order. The queue holds up to 8 entries. `data_out` shows the oldest byte, or 0 when nothing is held. `char_avail` is 1 whenever the queue or the holding register contains a byte.
- R2: `status_out` reports the presented byte's conditions: bit 7 overrun, bit 6 end of frame, bit 0 short frame. All other bits are 0.
- R3: A `rd_data` pulse retires the presented byte. The next entry's data and status appear one cycle later. A pulse while nothing is held changes nothing.
- R4: In mode 00 with threshold 0, the block is armed out of reset. `rx_irq` goes high one cycle after the first byte enters the queue, and the arming is consumed. `rx_irq` drops after the next `rd_data`. Later bytes do not raise it again.
- R5: A `cmd_rearm` pulse clears a pending mode-00 interrupt and arms the block again. The next byte that enters the queue raises `rx_irq`.
- R6: In mode 01, `rx_irq` is 1 exactly while the queued count is strictly greater than `cfg_thresh`.
- R7: In mode 00 with a non-zero threshold, and in modes 10 and 11, `rx_irq` stays 0.
- R8: A byte that arrives with any condition flag raises `sp_irq` one cycle later and locks the block.
- R9: A flagged byte is appended to the queue only when the mode is 01 and the queued count is below the threshold. Otherwise it goes to the holding register, which is presented and read before any queued byte.
- R10: While the block is locked, arriving bytes are dropped and status bit 7 is set.
- R11: A byte that arrives at a full, unlocked queue is dropped. It sets status bit 7, raises `sp_irq` and locks the block.
- R12: `cmd_err_reset` clears bit 7 and the presented entry's condition bits, and releases the lock. `sp_irq` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_data | input | 8 | Received byte |
| in_ovr | input | 1 | Overrun flag from the deframer |
| in_eof | input | 1 | Closing flag seen with this byte |
| in_short | input | 1 | Frame shorter than 32 bits |
| cfg_mode | input | 2 | Receive interrupt mode: 00 first character, 01 threshold |
| cfg_thresh | input | 3 | Queue threshold |
| rd_data | input | 1 | Read strobe, retires the presented byte |
| cmd_err_reset | input | 1 | Error-reset command pulse |
| cmd_rearm | input | 1 | Re-arm first-character interrupt pulse |
| data_out | output | 8 | Presented byte |
| status_out | output | 8 | Status of the presented byte |
| char_avail | output | 1 | At least one byte held |
| rx_irq | output | 1 | Receive interrupt, level |
| sp_irq | output | 1 | Special-condition interrupt, level; equals lock |

## Verification
Each internal fault shows up at the ports within one or two reads.

- A corrupted read or write pointer shows up as a wrong byte or status at the next read.
- A miscounted fill level shifts the threshold edge of `rx_irq` by one byte. It also moves the point at which a flagged byte is parked instead of queued, so the order of the data read back changes.
- A lock that is not released keeps `sp_irq` high in the cycle after error reset.
- A lock that is not enforced lets a dropped byte reappear as an extra character once the queue drains.
- A lost arming flag leaves `rx_irq` low one cycle after the first character.

// File: rtl/hdlc_rxq_pkg.sv
package hdlc_rxq_pkg;

  localparam int COND_W = 3;

  localparam logic [1:0] MODE_FIRST  = 2'b00;
  localparam logic [1:0] MODE_THRESH = 2'b01;

  typedef struct packed {
    logic ovr;
    logic eof;
    logic shrt;
  } cond_t;

  function automatic logic [7:0] status_byte(input cond_t c);
    return {c.ovr, c.eof, 5'b00000, c.shrt};
  endfunction

  function automatic logic any_cond(input cond_t c);
    return c.ovr | c.eof | c.shrt;
  endfunction

endpackage

// File: rtl/hdlc_rxq_store.sv
module hdlc_rxq_store #(
  parameter int DEPTH = 8,
  parameter int W     = 11,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          pop,
  input  logic          clr_cond,
  output logic [W-1:0]  head_word,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CB = hdlc_rxq_pkg::COND_W;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr_cond && !empty && !do_pop)
      mem[rd_ptr][W-1 -: CB] <= '0;
    if (do_push)
      mem[wr_ptr] <= push_word;
  end

  assign head_word = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/hdlc_rxq_irqgen.sv
module hdlc_rxq_irqgen #(
  parameter int TW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [TW-1:0] thresh,
  input  logic [CW-1:0] count,
  input  logic          enq,
  input  logic          rd_evt,
  input  logic          rearm,
  output logic          rx_irq
);
  import hdlc_rxq_pkg::*;

  logic armed, fired, first_ok;

  assign first_ok = (mode == MODE_FIRST) && (thresh == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
      fired <= 1'b0;
    end else if (rearm) begin
      armed <= 1'b1;
      fired <= 1'b0;
    end else if (enq && armed && first_ok) begin
      armed <= 1'b0;
      fired <= 1'b1;
    end else if (rd_evt) begin
      fired <= 1'b0;
    end
  end

  always_comb begin
    if (mode == MODE_THRESH) rx_irq = (count > CW'(thresh));
    else if (first_ok)       rx_irq = fired;
    else                     rx_irq = 1'b0;
  end
endmodule

// File: rtl/hdlc_rxq_ctrl.sv
module hdlc_rxq_ctrl #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_ovr,
  input  logic          in_eof,
  input  logic          in_short,
  input  logic [1:0]    cfg_mode,
  input  logic [TW-1:0] cfg_thresh,
  input  logic          rd_data,
  input  logic          cmd_err_reset,
  input  logic          cmd_rearm,
  output logic [DW-1:0] data_out,
  output logic [7:0]    status_out,
  output logic          char_avail,
  output logic          rx_irq,
  output logic          sp_irq
);
  import hdlc_rxq_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam int W  = DW + COND_W;

  cond_t         in_cond, head_cond, hold_cond, shown_cond;
  logic [W-1:0]  head_word;
  logic [CW-1:0] count;
  logic          full, empty;
  logic          lock, ovr_sticky;
  logic          hold_valid;
  logic [DW-1:0] hold_data;

  // named events used by the checker
  logic accept, has_cond, queue_special, push, pop, to_hold;
  logic full_drop, lock_drop, sp_evt, hold_rd;

  assign in_cond       = '{ovr: in_ovr, eof: in_eof, shrt: in_short};
  assign has_cond      = any_cond(in_cond);
  assign accept        = in_valid && !lock;
  assign queue_special = (cfg_mode == MODE_THRESH) && (count < CW'(cfg_thresh));
  assign push          = accept && !full && (!has_cond || queue_special);
  assign to_hold       = accept && has_cond && !queue_special;
  assign full_drop     = accept && !has_cond && full;
  assign lock_drop     = in_valid && lock;
  assign sp_evt        = (accept && has_cond) || full_drop;
  assign hold_rd       = rd_data && hold_valid;
  assign pop           = rd_data && !hold_valid && !empty;

  hdlc_rxq_store #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word ({in_cond, in_data}),
    .pop       (pop),
    .clr_cond  (cmd_err_reset && !hold_valid),
    .head_word (head_word),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  hdlc_rxq_irqgen #(.TW(TW), .CW(CW)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (cfg_mode),
    .thresh (cfg_thresh),
    .count  (count),
    .enq    (push),
    .rd_evt (pop || hold_rd),
    .rearm  (cmd_rearm),
    .rx_irq (rx_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock       <= 1'b0;
      ovr_sticky <= 1'b0;
      hold_valid <= 1'b0;
      hold_data  <= '0;
      hold_cond  <= '0;
    end else begin
      if (sp_evt)             lock <= 1'b1;
      else if (cmd_err_reset) lock <= 1'b0;

      if (full_drop || lock_drop) ovr_sticky <= 1'b1;
      else if (cmd_err_reset)     ovr_sticky <= 1'b0;

      if (to_hold) begin
        hold_valid <= 1'b1;
        hold_data  <= in_data;
        hold_cond  <= in_cond;
      end else if (hold_rd) begin
        hold_valid <= 1'b0;
      end else if (cmd_err_reset) begin
        hold_cond  <= '0;
      end
    end
  end

  assign head_cond  = cond_t'(head_word[W-1 -: COND_W]);
  assign shown_cond = hold_valid ? hold_cond : head_cond;
  assign data_out   = hold_valid ? hold_data : head_word[DW-1:0];
  assign status_out = status_byte(shown_cond) | {ovr_sticky, 7'b0};
  assign char_avail = hold_valid || !empty;
  assign sp_irq     = lock;
endmodule

// File: rtl/hdlc_rxq_chk.sv
module hdlc_rxq_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          push,
  input logic          pop,
  input logic          sp_evt,
  input logic          sp_irq,
  input logic          cmd_err_reset,
  input logic          in_valid
);
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_no_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  p_lock_blocks_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_irq && in_valid) |-> !push);

  p_sp_follows_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_evt |=> sp_irq);

  p_err_unlocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err_reset && sp_irq) |=> !sp_irq);

  p_pop_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - CW'(1)));
endmodule

bind hdlc_rxq_ctrl hdlc_rxq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .count         (count),
  .full          (full),
  .push          (push),
  .pop           (pop),
  .sp_evt        (sp_evt),
  .sp_irq        (sp_irq),
  .cmd_err_reset (cmd_err_reset),
  .in_valid      (in_valid)
);

// File: tb/test_hdlc_rxq_ctrl.sv
module test_hdlc_rxq_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ovr = 1'b0, in_eof = 1'b0, in_short = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_mode = 2'b00;
  logic [2:0] cfg_thresh = 3'd0;
  logic       rd_data = 1'b0, cmd_err_reset = 1'b0, cmd_rearm = 1'b0;
  logic [7:0] data_out, status_out;
  logic       char_avail, rx_irq, sp_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hdlc_rxq_ctrl i_hdlc_rxq_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ovr(in_ovr), .in_eof(in_eof), .in_short(in_short),
    .cfg_mode(cfg_mode), .cfg_thresh(cfg_thresh), .rd_data(rd_data),
    .cmd_err_reset(cmd_err_reset), .cmd_rearm(cmd_rearm),
    .data_out(data_out), .status_out(status_out), .char_avail(char_avail),
    .rx_irq(rx_irq), .sp_irq(sp_irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // bytes are driven for one cycle starting at a falling edge;
  // results are sampled at the next falling edge
  task automatic send(input logic [7:0] d, input logic [2:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; {in_ovr, in_eof, in_short} = c;
    @(negedge clk);
    in_valid = 1'b0; {in_ovr, in_eof, in_short} = 3'b000;
  endtask

  task automatic rd();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic err_reset();
    @(negedge clk); cmd_err_reset = 1'b1;
    @(negedge clk); cmd_err_reset = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); cmd_rearm = 1'b1;
    @(negedge clk); cmd_rearm = 1'b0;
  endtask

  task automatic take(input string req, input logic [7:0] d, input logic [7:0] s);
    check(req, "data", data_out, d);
    check(req, "status", status_out, s);
    rd();
  endtask

  task automatic t_reset();
    check("R1", "avail after reset", char_avail, 0);
    check("R1", "data after reset", data_out, 0);
    check("R2", "status after reset", status_out, 0);
    check("R8", "sp after reset", sp_irq, 0);
    check("R4", "rx after reset", rx_irq, 0);
  endtask

  task automatic t_first_char();
    cfg_mode = 2'b00; cfg_thresh = 3'd0;
    send(8'h11, 3'b000);
    check("R4", "rx after first byte", rx_irq, 1);
    send(8'h22, 3'b000);
    check("R4", "rx held", rx_irq, 1);
    take("R1", 8'h11, 8'h00);
    check("R4", "rx cleared by read", rx_irq, 0);
    send(8'h33, 3'b000);
    check("R4", "no refire", rx_irq, 0);
    rearm();
    check("R5", "rx after rearm", rx_irq, 0);
    send(8'h44, 3'b000);
    check("R5", "rx after rearm+byte", rx_irq, 1);
    take("R1", 8'h22, 8'h00);
    take("R1", 8'h33, 8'h00);
    take("R1", 8'h44, 8'h00);
    check("R1", "drained", char_avail, 0);
  endtask

  task automatic t_fifo_order();
    cfg_mode = 2'b01; cfg_thresh = 3'd7;
    send(8'hA1, 3'b000);
    check("R1", "avail", char_avail, 1);
    send(8'hB2, 3'b000);
    send(8'hC3, 3'b000);
    take("R3", 8'hA1, 8'h00);
    take("R3", 8'hB2, 8'h00);
    take("R3", 8'hC3, 8'h00);
    check("R1", "empty", char_avail, 0);
    rd();
    check("R3", "empty read avail", char_avail, 0);
    check("R3", "empty read data", data_out, 0);
  endtask

  task automatic t_threshold();
    cfg_mode = 2'b01; cfg_thresh = 3'd2;
    send(8'h01, 3'b000);
    send(8'h02, 3'b000);
    check("R6", "count==thresh", rx_irq, 0);
    send(8'h03, 3'b000);
    check("R6", "count>thresh", rx_irq, 1);
    take("R6", 8'h01, 8'h00);
    check("R6", "back to thresh", rx_irq, 0);
    take("R1", 8'h02, 8'h00);
    take("R1", 8'h03, 8'h00);
  endtask

  task automatic t_invalid_modes();
    cfg_mode = 2'b00; cfg_thresh = 3'd3;
    rearm();
    send(8'h5A, 3'b000);
    check("R7", "mode00 nonzero thresh", rx_irq, 0);
    cfg_mode = 2'b10; cfg_thresh = 3'd0;
    send(8'h5B, 3'b000);
    check("R7", "mode10", rx_irq, 0);
    cfg_mode = 2'b11;
    @(negedge clk);
    check("R7", "mode11", rx_irq, 0);
    take("R1", 8'h5A, 8'h00);
    take("R1", 8'h5B, 8'h00);
  endtask

  task automatic t_special_queued();
    cfg_mode = 2'b01; cfg_thresh = 3'd3;
    send(8'h10, 3'b000);
    send(8'h55, 3'b010);
    check("R8", "sp after eof byte", sp_irq, 1);
    take("R9", 8'h10, 8'h00);
    check("R2", "eof status data", data_out, 8'h55);
    check("R2", "eof status bit6", status_out, 8'h40);
    send(8'h66, 3'b000);
    check("R10", "ovr while locked", status_out, 8'hC0);
    err_reset();
    check("R12", "sp released", sp_irq, 0);
    check("R12", "status cleared", status_out, 8'h00);
    take("R12", 8'h55, 8'h00);
    check("R10", "locked byte dropped", char_avail, 0);
  endtask

  task automatic t_special_hold();
    cfg_mode = 2'b01; cfg_thresh = 3'd1;
    send(8'h21, 3'b000);
    send(8'h22, 3'b000);
    send(8'h77, 3'b001);
    check("R8", "sp after short byte", sp_irq, 1);
    take("R9", 8'h77, 8'h01);
    take("R9", 8'h21, 8'h00);
    err_reset();
    check("R12", "sp released", sp_irq, 0);
    take("R9", 8'h22, 8'h00);
    check("R9", "drained", char_avail, 0);
  endtask

  task automatic t_full();
    cfg_mode = 2'b01; cfg_thresh = 3'd7;
    for (int i = 0; i < 8; i++) send(8'h80 + 8'(i), 3'b000);
    check("R11", "no sp at full", sp_irq, 0);
    send(8'hEE, 3'b000);
    check("R11", "sp on full drop", sp_irq, 1);
    check("R11", "ovr on full drop", status_out, 8'h80);
    err_reset();
    check("R12", "ovr cleared", status_out, 8'h00);
    for (int i = 0; i < 8; i++) take("R11", 8'h80 + 8'(i), 8'h00);
    check("R11", "extra byte dropped", char_avail, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_char();
    t_fifo_order();
    t_threshold();
    t_invalid_modes();
    t_special_queued();
    t_special_hold();
    t_full();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule